// File: doc/BRIEF.md
# Converter Fault Status Register

This block gathers the fault and state indications of a power converter controller into one 16-bit status word for a register read path. The low byte can also be read alone as a status byte. Fault detectors feed it one level or pulse per clock for output overvoltage, output overcurrent, input undervoltage, overtemperature and communication/memory/logic faults. It also receives the live output-delivery state and the power-good pin level.

Two kinds of bits share the word. Raw bits follow their inputs in the same cycle. Sticky flags capture a fault and hold it after the condition has gone. A sticky flag is cleared by a clear-faults strobe, by a fresh rising edge of the output enable request, or by reset. If the fault is still present when the clear arrives, the flag sets again in that same cycle. An active-low alert line stays asserted while any sticky flag is set.

Top module: `fault_status_word`

## Requirements
- R1: After reset every sticky flag reads 0 and `alert_n` is 1.
- R2: Word bits 0, 7, 8, 9, 10 and 12 always read 0.
- R3: Word bit 6 is raw. It reads 1 in any cycle in which `out_active` is 0, and 0 while `out_active` is 1.
- R4: Word bit 11 is raw. It reads 1 while `pgood_pin` is 0 and 0 while it is 1.
- R5: The sticky detail flags are bit 5 (`ov_evt`), bit 4 (`oc_evt`), bit 3 (`vin_uv_evt`), bit 2 (`ot_evt`) and bit 1 (`cml_evt`). A flag reads 1 from the clock edge that samples its input high, and it stays 1 after the input falls.
- R6: The sticky summary flags are bit 15 (set by `ov_evt`), bit 14 (set by `oc_evt`) and bit 13 (set by `vin_uv_evt`). They latch and hold in the same way as the detail flags.
- R7: A `clr_strobe` sampled high clears every sticky flag at that edge.
- R8: A sampled `en_req` of 1, when the previous sample was 0, clears every sticky flag. The first sample after reset counts as following a 0. While `en_req` stays low, no flag is cleared.
- R9: When a fault input and a clear are sampled at the same edge, the set wins. A fault held across a clear keeps its flags at 1 and keeps `alert_n` low.
- R10: `alert_n` is 0 while any sticky flag is 1, and 1 while all of them are 0.
- R11: `status_byte` always equals bits 7 to 0 of `status_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_evt | input | 1 | Output overvoltage condition |
| oc_evt | input | 1 | Output overcurrent condition |
| vin_uv_evt | input | 1 | Input below undervoltage turn-on threshold |
| ot_evt | input | 1 | Overtemperature condition |
| cml_evt | input | 1 | Communication, memory or logic fault |
| out_active | input | 1 | 1 while the converter delivers output power |
| pgood_pin | input | 1 | Power-good pin level |
| clr_strobe | input | 1 | Clear-faults command, one cycle |
| en_req | input | 1 | Output enable request |
| status_word | output | 16 | Status word |
| status_byte | output | 8 | Low byte of the status word |
| alert_n | output | 1 | Active-low alert |

## Verification
A sticky flag stuck at 0 or 1, or one that loses its set-over-clear priority, shows in the status word and on `alert_n` one edge after the stimulus that should have moved it. The bench compares the whole word and the alert after every edge, so such a fault is reported within a cycle. A wrong enable history corrupts the off-then-on clear. This shows only at the next enable rise, so the bench holds the request low for a cycle before raising it, and also raises it while a fault is still active. Swapped raw or summary positions appear in the same cycle because the full word is compared against a model.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int DETAIL_N  = 5;   // cml, ot, uv, oc, ov
    localparam int SUMMARY_N = 3;   // input, iout, vout
    localparam int DET_LSB   = 1;
    localparam int SUM_LSB   = 13;
    localparam int POS_OFF   = 6;
    localparam int POS_PGN   = 11;

    typedef struct packed {
        logic en;
    } clr_state_t;
endpackage

// File: rtl/fsw_clear_gen.sv
module fsw_clear_gen
    import fsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_strobe,
    input  logic en_req,
    output logic clr_all
);
    clr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = en_req;
        clr_all = clr_strobe | (en_req & ~st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a held-low request never produces a clear unless strobed
    assert_low_en_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_req && !clr_strobe) |-> !clr_all);
endmodule

// File: rtl/fsw_flag_bank.sv
module fsw_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flg;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr_i) b_d.flg = '0;
        b_d.flg = b_d.flg | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign flags_o = b_q.flg;

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
        assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i) |=> flags_o[i]);
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[i]) |=> !flags_o[i]);
    end
endmodule

// File: rtl/fsw_word_pack.sv
module fsw_word_pack
    import fsw_pkg::*;
(
    input  logic [DETAIL_N-1:0]  det_i,
    input  logic [SUMMARY_N-1:0] sum_i,
    input  logic                 out_active,
    input  logic                 pgood_pin,
    output logic [WORD_W-1:0]    word_o
);
    always_comb begin
        word_o = '0;
        for (int i = 0; i < DETAIL_N; i++)  word_o[DET_LSB + i] = det_i[i];
        for (int i = 0; i < SUMMARY_N; i++) word_o[SUM_LSB + i] = sum_i[i];
        word_o[POS_OFF] = ~out_active;
        word_o[POS_PGN] = ~pgood_pin;
    end
endmodule

// File: rtl/fault_status_word.sv
module fault_status_word
    import fsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ov_evt,
    input  logic              oc_evt,
    input  logic              vin_uv_evt,
    input  logic              ot_evt,
    input  logic              cml_evt,
    input  logic              out_active,
    input  logic              pgood_pin,
    input  logic              clr_strobe,
    input  logic              en_req,
    output logic [WORD_W-1:0] status_word,
    output logic [BYTE_W-1:0] status_byte,
    output logic              alert_n
);
    logic                 clr_all;
    logic [DETAIL_N-1:0]  det_set, det_q;
    logic [SUMMARY_N-1:0] sum_set, sum_q;

    always_comb begin
        det_set = {ov_evt, oc_evt, vin_uv_evt, ot_evt, cml_evt};
        sum_set = {ov_evt, oc_evt, vin_uv_evt};
    end

    fsw_clear_gen u_clr (
        .clk(clk), .rst_n(rst_n), .clr_strobe(clr_strobe),
        .en_req(en_req), .clr_all(clr_all)
    );

    fsw_flag_bank #(.N(DETAIL_N)) u_det (
        .clk(clk), .rst_n(rst_n), .set_i(det_set), .clr_i(clr_all), .flags_o(det_q)
    );

    fsw_flag_bank #(.N(SUMMARY_N)) u_sum (
        .clk(clk), .rst_n(rst_n), .set_i(sum_set), .clr_i(clr_all), .flags_o(sum_q)
    );

    fsw_word_pack u_pack (
        .det_i(det_q), .sum_i(sum_q), .out_active(out_active),
        .pgood_pin(pgood_pin), .word_o(status_word)
    );

    always_comb begin
        status_byte = status_word[BYTE_W-1:0];
        alert_n     = ~(|det_q | |sum_q);
    end

    assert_alert_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_word[DET_LSB +: DETAIL_N]) |-> !alert_n);
    assert_alert_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|status_word[DET_LSB +: DETAIL_N]) && !(|status_word[SUM_LSB +: SUMMARY_N]))
        |-> alert_n);
    assert_relatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ov_evt |=> (status_word[5] && status_word[15] && !alert_n));
endmodule

// File: tb/sim_fault_status_word.sv
`timescale 1ns/1ps
module sim_fault_status_word;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ov = 0, oc = 0, uv = 0, ot = 0, cml = 0;
    logic act = 0, pg = 1, clr = 0, en = 0;
    logic [15:0] word;
    logic [7:0]  sbyte;
    logic        alert_n;

    always #4 clk = ~clk;   // 125 MHz

    fault_status_word u0 (
        .clk(clk), .rst_n(rst_n), .ov_evt(ov), .oc_evt(oc), .vin_uv_evt(uv),
        .ot_evt(ot), .cml_evt(cml), .out_active(act), .pgood_pin(pg),
        .clr_strobe(clr), .en_req(en), .status_word(word),
        .status_byte(sbyte), .alert_n(alert_n)
    );

    typedef struct {
        logic [15:0] w;
        logic        a;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    logic [4:0] m_det = 0;   // {ov,oc,uv,ot,cml}
    logic [2:0] m_sum = 0;   // {vout,iout,input}
    logic       m_en  = 0;
    bit         done  = 0;

    task automatic push_exp(string tag);
        exp_t e;
        e.w = 16'h0;
        e.w[6]     = ~act;
        e.w[11]    = ~pg;
        e.w[5:1]   = m_det;
        e.w[15:13] = m_sum;
        e.a   = ~(|m_det | |m_sum);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input logic [4:0] ev, input logic c, input logic e_r,
                        input logic a, input logic p, input string tag);
        logic cl;
        @(negedge clk);
        rst_n = 1'b1;
        {ov, oc, uv, ot, cml} = ev;
        clr = c; en = e_r; act = a; pg = p;
        cl    = c | (e_r & ~m_en);
        m_en  = e_r;
        m_det = (cl ? 5'b0 : m_det) | ev;
        m_sum = (cl ? 3'b0 : m_sum) | {ev[4], ev[3], ev[2]};
        push_exp(tag);
    endtask

    task automatic rst_step(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        {ov, oc, uv, ot, cml} = 5'b0;
        clr = 0; en = 0; act = 0; pg = 1;
        m_det = 0; m_sum = 0; m_en = 0;
        push_exp(tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (word !== e.w || alert_n !== e.a) begin
                    errors++;
                    $display("FAIL %s word=%h alert_n=%b expected word=%h alert_n=%b",
                             e.tag, word, alert_n, e.w, e.a);
                end
                checks++;
                if (sbyte !== word[7:0]) begin
                    errors++;
                    $display("FAIL R11 byte=%h expected %h", sbyte, word[7:0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        rst_step("R1 reset");
        rst_step("R1 reset hold");
        step(5'b00000, 0, 1, 0, 1, "R1 R2 idle after reset");
        step(5'b00000, 0, 1, 1, 0, "R3 R4 raw on/pg low");
        step(5'b00000, 0, 1, 0, 1, "R3 R4 raw off/pg high");
        step(5'b10000, 0, 1, 1, 1, "R5 R6 ov set");
        step(5'b00000, 0, 1, 1, 1, "R5 R6 R10 ov held");
        step(5'b00000, 1, 1, 1, 1, "R7 clear");
        step(5'b01000, 0, 1, 1, 1, "R5 R6 oc set");
        step(5'b00100, 0, 1, 1, 1, "R5 R6 uv set");
        step(5'b00010, 0, 1, 1, 1, "R5 ot set");
        step(5'b00001, 0, 1, 1, 1, "R5 cml set");
        step(5'b00000, 0, 1, 1, 1, "R2 R10 all held");
        step(5'b00000, 1, 1, 1, 1, "R7 clear all");
        step(5'b00000, 0, 1, 1, 1, "R10 alert released");
        step(5'b10000, 0, 1, 1, 1, "R9 ov before clear");
        step(5'b10000, 1, 1, 1, 1, "R9 set beats clear");
        step(5'b00000, 0, 1, 1, 1, "R9 relatched held");
        step(5'b00001, 0, 0, 0, 1, "R8 en low keeps flags");
        step(5'b00000, 0, 0, 0, 1, "R8 en low no clear");
        step(5'b00000, 0, 1, 1, 1, "R8 en rise clears");
        step(5'b00000, 0, 1, 1, 1, "R8 en high no clear");
        step(5'b00100, 0, 1, 1, 0, "R6 uv summary");
        step(5'b00000, 0, 0, 0, 0, "R8 en low");
        step(5'b00100, 0, 1, 1, 0, "R9 en rise with uv active");
        step(5'b00000, 0, 1, 1, 1, "R9 held after rise");
        step(5'b01000, 1, 1, 1, 1, "R9 oc with clear");
        step(5'b00000, 1, 1, 1, 1, "R7 final clear");
        step(5'b00000, 0, 1, 1, 1, "R10 final idle");
        @(posedge clk);
        #3;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule